// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous memory array and turns a set of strobes into the array address and the kind of access for each clock cycle. An external address is captured when either of two address strobes asks for it: the processor-side strobe or the controller-side strobe. Once an address is captured, the advance input walks the low offset bits through a four-beat burst, or the sequencer holds the address in place while a burst is suspended. The upper address bits never change inside a burst.

The low offset bits step either in plain ascending order with wrap-around or in an exclusive-or order. In exclusive-or order each beat is the starting offset XOR the beat number. A static order-select input chooses between the two orders. The three chip-select inputs decide whether a strobe starts an access or deselects the device. Every cycle the block produces a registered command code for the storage array and output stage to act on. A new address may be captured on every cycle, so a user that never bursts loses no bandwidth.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, `arr_addr` is all zeros, `cmd` is 0 (deselect) and `cyc_wr` is 0.
- R2: With `order_xor` = 0, beat k of a burst (k = 0..3) presents low offset (start + k) mod 4, where start is the captured address bits [1:0].
- R3: With `order_xor` = 1, beat k presents low offset start XOR k. From starts 0,1,2,3 the sequences are 0,1,2,3 / 1,0,3,2 / 2,3,0,1 / 3,2,1,0.
- R4: A fourth advance after the capture cycle returns the low offset to the starting offset.
- R5: When `sel_main_n` = 0, `sel_pos` = 1, `sel_neg_n` = 0 and `pstrb_n` = 0, the address `addr_in` is captured and `cmd` becomes 1 (read) with `cyc_wr` = 0, whatever `wr_req` is.
- R6: When `pstrb_n` = 1 (or `sel_main_n` = 1 masks it), `cstrb_n` = 0 and all three selects are true, `addr_in` is captured and `cmd` becomes 2 (write) with `cyc_wr` = 1 if `wr_req` = 1, else 1 (read) with `cyc_wr` = 0.
- R7: With no effective strobe, `adv_n` = 0 steps to the next burst offset with `cmd` = 3 (continue), and `adv_n` = 1 keeps the address unchanged with `cmd` = 4 (suspend). In both cases `cyc_wr` follows `wr_req`. A low `pstrb_n` while `sel_main_n` = 1 counts as no strobe.
- R8: The command is 0 (deselect), with `cyc_wr` = 0 and the address held, in three cases. The first is `sel_main_n` = 1 with `cstrb_n` = 0. The second is `sel_pos` = 0 or `sel_neg_n` = 1 while an effective strobe is low. The third is `sel_main_n` = 0 with `pstrb_n` = 0 while either of those two selects is false.
- R9: Bits above the two offset bits of `arr_addr` do not change on continue or suspend cycles.
- R10: Captures on consecutive cycles each present their own new address in the following cycle.
- Results of a cycle's inputs appear on `arr_addr`, `cmd` and `cyc_wr` after that cycle's rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address to capture |
| pstrb_n | input | 1 | Processor-side address strobe, active low |
| cstrb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_main_n | input | 1 | Main chip select, active low |
| sel_pos | input | 1 | Secondary chip select, active high |
| sel_neg_n | input | 1 | Secondary chip select, active low |
| wr_req | input | 1 | Access direction: 1 write, 0 read |
| order_xor | input | 1 | Burst order: 0 ascending, 1 exclusive-or |
| arr_addr | output | ADDR_W | Array address for the current cycle |
| cmd | output | 3 | 0 deselect, 1 read, 2 write, 3 continue, 4 suspend |
| cyc_wr | output | 1 | Direction of the current access |

## Verification
On every cycle the assertions check four things: a capture presents the captured address, a step changes the offset by one in ascending order and flips bit 0 in exclusive-or order, the upper bits stay put across steps, and suspend or deselect leaves the address alone. They also tie each decoded event to its command code. Only the bench scenarios can show the full per-start sequences in both orders, the wrap on the fifth beat, and the exact precedence between strobes and selects. The bench also covers the read-only nature of processor-strobe captures and back-to-back captures.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_CONT  = 3'd3,
    CMD_SUSP  = 3'd4
  } cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_seq_pkg::*;
(
  input  logic pstrb_n,
  input  logic cstrb_n,
  input  logic adv_n,
  input  logic sel_main_n,
  input  logic sel_pos,
  input  logic sel_neg_n,
  input  logic wr_req,
  output logic ev_load,
  output logic ev_step,
  output logic ev_hold,
  output logic ev_desel,
  output cmd_e next_cmd,
  output logic next_wr
);
  logic sec_sel_ok;
  logic pstrb_eff;

  assign sec_sel_ok = sel_pos & ~sel_neg_n;
  // processor strobe only counts when the main select is active
  assign pstrb_eff  = ~sel_main_n & ~pstrb_n;

  always_comb begin
    ev_load  = 1'b0;
    ev_step  = 1'b0;
    ev_hold  = 1'b0;
    ev_desel = 1'b0;
    next_cmd = CMD_DESEL;
    next_wr  = 1'b0;
    if (pstrb_eff) begin
      if (sec_sel_ok) begin
        ev_load  = 1'b1;
        next_cmd = CMD_READ;
      end else begin
        ev_desel = 1'b1;
      end
    end else if (!cstrb_n) begin
      if (!sel_main_n && sec_sel_ok) begin
        ev_load  = 1'b1;
        next_cmd = wr_req ? CMD_WRITE : CMD_READ;
        next_wr  = wr_req;
      end else begin
        ev_desel = 1'b1;
      end
    end else if (!adv_n) begin
      ev_step  = 1'b1;
      next_cmd = CMD_CONT;
      next_wr  = wr_req;
    end else begin
      ev_hold  = 1'b1;
      next_cmd = CMD_SUSP;
      next_wr  = wr_req;
    end
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_step,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int UP_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  beat_q;

  function automatic logic [OFS_W-1:0] beat_ofs(
    input logic [OFS_W-1:0] start,
    input logic [OFS_W-1:0] beat,
    input logic             use_xor
  );
    return use_xor ? (start ^ beat) : OFS_W'(start + beat);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (ev_load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (ev_step) begin
      beat_q <= OFS_W'(beat_q + 1'b1);
    end
  end

  assign arr_addr = {base_q[ADDR_W-1:OFS_W],
                     beat_ofs(base_q[OFS_W-1:0], beat_q, order_xor)};

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> arr_addr == $past(addr_in)); // R5
  AST_UPPER_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> arr_addr[ADDR_W-1:OFS_W] == $past(arr_addr[ADDR_W-1:OFS_W])); // R9
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && !ev_step && $stable(order_xor)) |=> $stable(arr_addr)); // R7
  AST_ASC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !order_xor) |=>
      arr_addr[OFS_W-1:0] == OFS_W'($past(arr_addr[OFS_W-1:0]) + 1'b1)); // R2
  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && order_xor) |=> arr_addr[0] != $past(arr_addr[0])); // R3

  if (UP_W < 1) begin : g_width_check
    initial $error("ADDR_W must exceed OFS_W");
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              pstrb_n,
  input  logic              cstrb_n,
  input  logic              adv_n,
  input  logic              sel_main_n,
  input  logic              sel_pos,
  input  logic              sel_neg_n,
  input  logic              wr_req,
  input  logic              order_xor,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [2:0]        cmd,
  output logic              cyc_wr
);
  logic ev_load, ev_step, ev_hold, ev_desel;
  cmd_e next_cmd, cmd_q;
  logic next_wr, wr_q;

  burst_cmd_decode u_dec (
    .pstrb_n   (pstrb_n),
    .cstrb_n   (cstrb_n),
    .adv_n     (adv_n),
    .sel_main_n(sel_main_n),
    .sel_pos   (sel_pos),
    .sel_neg_n (sel_neg_n),
    .wr_req    (wr_req),
    .ev_load   (ev_load),
    .ev_step   (ev_step),
    .ev_hold   (ev_hold),
    .ev_desel  (ev_desel),
    .next_cmd  (next_cmd),
    .next_wr   (next_wr)
  );

  burst_addr_counter #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_load  (ev_load),
    .ev_step  (ev_step),
    .order_xor(order_xor),
    .addr_in  (addr_in),
    .arr_addr (arr_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_DESEL;
      wr_q  <= 1'b0;
    end else begin
      cmd_q <= next_cmd;
      wr_q  <= next_wr;
    end
  end

  assign cmd    = cmd_q;
  assign cyc_wr = wr_q;

  AST_DESEL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> (cmd == 3'd0 && !cyc_wr && $stable(arr_addr))); // R8
  AST_LOAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (cmd == 3'd1 || cmd == 3'd2)); // R6
  AST_STEP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> cmd == 3'd3); // R7
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> cmd == 3'd4); // R7
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ev_load, ev_step, ev_hold, ev_desel})); // R8
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/100ps
module tb_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
  logic sel_main_n = 1'b0, sel_pos = 1'b1, sel_neg_n = 1'b0;
  logic wr_req = 1'b0, order_xor = 1'b0;
  logic [AW-1:0] arr_addr;
  logic [2:0]    cmd;
  logic          cyc_wr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // exclusive-or order, row = start offset, column = beat
  localparam logic [1:0] XSEQ [0:15] = '{2'd0, 2'd1, 2'd2, 2'd3,
                                         2'd1, 2'd0, 2'd3, 2'd2,
                                         2'd2, 2'd3, 2'd0, 2'd1,
                                         2'd3, 2'd2, 2'd1, 2'd0};

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .OFS_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
    .sel_main_n(sel_main_n), .sel_pos(sel_pos), .sel_neg_n(sel_neg_n),
    .wr_req(wr_req), .order_xor(order_xor),
    .arr_addr(arr_addr), .cmd(cmd), .cyc_wr(cyc_wr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, take one rising edge, return at next falling edge
  task automatic cyc(input logic ps, input logic cs, input logic adv,
                     input logic e1n, input logic e2, input logic e3n,
                     input logic wr, input logic [AW-1:0] a);
    pstrb_n = ps; cstrb_n = cs; adv_n = adv;
    sel_main_n = e1n; sel_pos = e2; sel_neg_n = e3n;
    wr_req = wr; addr_in = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 addr", 32'(arr_addr), 32'd0);
    chk("R1 cmd", 32'(cmd), 32'd0);
    chk("R1 wr", 32'(cyc_wr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_burst(input logic use_xor);
    logic [AW-3:0] up;
    order_xor = use_xor;
    for (int s = 0; s < 4; s++) begin
      up = 18'h2A5C3 + 18'(s * 7);
      cyc(1, 0, 1, 0, 1, 0, 0, {up, 2'(s)});
      chk("R6 load cmd", 32'(cmd), 32'd1);
      chk("R6 load addr", 32'(arr_addr), 32'({up, 2'(s)}));
      for (int k = 1; k < 5; k++) begin
        logic [1:0] e;
        cyc(1, 1, 0, 0, 1, 0, 0, '0);
        e = use_xor ? XSEQ[s*4 + (k % 4)] : 2'((s + k) % 4);
        if (k == 4) chk("R4 wrap", 32'(arr_addr[1:0]), 32'(s));
        else if (use_xor) chk("R3 xor beat", 32'(arr_addr[1:0]), 32'(e));
        else chk("R2 asc beat", 32'(arr_addr[1:0]), 32'(e));
        chk("R9 upper", 32'(arr_addr[AW-1:2]), 32'(up));
        chk("R7 cont cmd", 32'(cmd), 32'd3);
      end
    end
    order_xor = 1'b0;
  endtask

  task automatic t_pstrb();
    cyc(0, 1, 1, 0, 1, 0, 1, 20'hBEEF1);
    chk("R5 addr", 32'(arr_addr), 32'h0BEEF1);
    chk("R5 cmd read", 32'(cmd), 32'd1);
    chk("R5 wr ignored", 32'(cyc_wr), 32'd0);
    // masked processor strobe: counts as no strobe, advance steps
    cyc(0, 1, 0, 1, 1, 0, 1, 20'h12345);
    chk("R7 masked ps cmd", 32'(cmd), 32'd3);
    chk("R7 masked ps addr", 32'(arr_addr), 32'h0BEEF2);
    chk("R7 cont wr", 32'(cyc_wr), 32'd1);
  endtask

  task automatic t_suspend();
    cyc(1, 0, 1, 0, 1, 0, 1, 20'h40002);
    chk("R6 write cmd", 32'(cmd), 32'd2);
    chk("R6 write flag", 32'(cyc_wr), 32'd1);
    cyc(1, 1, 0, 0, 1, 0, 1, '0);
    chk("R7 step", 32'(arr_addr), 32'h40003);
    cyc(1, 1, 1, 0, 1, 0, 0, 20'hFFFFF);
    chk("R7 suspend cmd", 32'(cmd), 32'd4);
    chk("R7 suspend addr", 32'(arr_addr), 32'h40003);
    chk("R7 suspend wr", 32'(cyc_wr), 32'd0);
    cyc(1, 1, 1, 0, 1, 0, 0, 20'hFFFFF);
    chk("R9 suspend upper", 32'(arr_addr), 32'h40003);
  endtask

  task automatic t_desel();
    cyc(1, 0, 1, 0, 1, 0, 0, 20'h00500);
    cyc(1, 0, 1, 1, 1, 0, 1, 20'h77777);
    chk("R8 main off cmd", 32'(cmd), 32'd0);
    chk("R8 main off addr", 32'(arr_addr), 32'h00500);
    cyc(0, 1, 1, 0, 0, 1, 1, 20'h66666);
    chk("R8 ps sec off cmd", 32'(cmd), 32'd0);
    chk("R8 ps sec off addr", 32'(arr_addr), 32'h00500);
    cyc(1, 0, 1, 0, 1, 1, 1, 20'h55555);
    chk("R8 cs sec off cmd", 32'(cmd), 32'd0);
    chk("R8 cs sec off wr", 32'(cyc_wr), 32'd0);
    chk("R8 cs sec off addr", 32'(arr_addr), 32'h00500);
  endtask

  task automatic t_b2b();
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = 20'h1000 * 20'(i + 1) + 20'(i);
      if (i % 2 == 0) cyc(0, 1, 1, 0, 1, 0, 1, a);
      else cyc(1, 0, 1, 0, 1, 0, 1, a);
      chk("R10 b2b addr", 32'(arr_addr), 32'(a));
      chk("R10 b2b cmd", 32'(cmd), (i % 2 == 0) ? 32'd1 : 32'd2);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_burst(1'b0);
    t_burst(1'b1);
    t_pstrb();
    t_suspend();
    t_desel();
    t_b2b();
    done = 1;
    summary();
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule